// File: doc/BRIEF.md
# Front-End Serial Configuration Master

This block moves configuration words between a module controller and up to sixteen front-end chips over a slow serial bus. The bus has three lines shared by every chip: a data/address line, a load line and a validation clock. Readback comes in on the selected chip's own return line, which the chips also use for event data. The validation clock runs at one eighth of the system clock, so a 40 MHz system clock gives a 5 MHz bus. It runs only while a transfer is in progress. Outputs change on its falling edge and readback is sampled on its rising edge.

A transfer starts with an 8-bit address sent with the load line low. The upper four bits select a chip, and the value 15 addresses all chips at once. The lower four bits give a register code. A data phase of 1 to 32 bits follows with the load line high. A write drives the data bits; a read holds the data line low and collects bits from the chosen chip. The host offers a request for one cycle while the block is idle. A request is refused with a one-cycle error pulse in any of these cases: data taking is enabled, the length is illegal, or the request is a read from the broadcast address. If data taking is switched on during a transfer, the transfer is dropped at once.

Top module: `fe_cfg_master`

## Requirements
- R1: After reset, ser_clk, ser_dout, ser_load, busy, done and err are all low and rd_data is zero.
- R2: While busy, each bit lasts 8 system clocks. ser_clk is low for the first 4 clocks of a bit and high for the last 4. It stays low when not busy.
- R3: A transfer first sends the 8 address bits req_addr[7:0], MSB first, with ser_load low. req_addr[7:4] is the chip select and req_addr[3:0] is the register code.
- R4: After the address, ser_load is high for req_len bit periods. For a write, ser_dout carries req_wdata[req_len-1] down to req_wdata[0] in that order.
- R5: ser_dout and ser_load change only at the start of a bit period (the falling edge of ser_clk). They hold steady while ser_clk is high.
- R6: For a read, ser_dout stays low during the data phase. ser_din[req_addr[7:4]] is sampled in the last system clock before each rising ser_clk edge. The bits are shifted into rd_data MSB first and end up right-justified, with the upper bits zero.
- R7: done pulses high for exactly one cycle. This is the cycle in which busy falls after the last bit period ends normally.
- R8: A request made while run_en is high produces a one-cycle err pulse and no bus activity.
- R9: A read with chip select 15 produces a one-cycle err pulse and no bus activity. A write to chip select 15 is carried out.
- R10: A request with req_len of 0 or greater than 32 produces a one-cycle err pulse and no bus activity.
- R11: If run_en is high during a transfer, the transfer is dropped. In the next cycle busy and all bus lines are low and err pulses, and done does not pulse.
- R12: req_valid has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Data taking active; locks out the bus |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Chip select [7:4] and register code [3:0] |
| req_len | input | 6 | Data length in bits, 1 to 32 |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| err | output | 1 | One-cycle pulse on refusal or abort |
| rd_data | output | 32 | Readback word, right-justified |
| ser_clk | output | 1 | Slow validation clock |
| ser_dout | output | 1 | Broadcast data/address line |
| ser_load | output | 1 | Low during address, high during data |
| ser_din | input | 16 | Per-chip return lines |

## Verification
The bench targets both ends of the length range and the boundary between the address and data phases. A design with an off-by-one here would send one bit too many or too few, or raise the load line one period late. Reads use a random return pattern and a constant pattern. A design that samples on the wrong edge, reads the wrong chip's line or packs the bits in the wrong order would return a wrong word. Other runs stack the refusal conditions, raise run_en partway through a transfer, and issue a stray request while busy. A design that queued requests, finished an aborted transfer or restarted on the stray request would show bus activity where none belongs.

// File: rtl/fe_cfg_master.sv
module fe_cfg_master #(
  parameter int DIV     = 8,
  parameter int NCHIP   = 16,
  parameter int CHIP_W  = 4,
  parameter int REG_W   = 4,
  parameter int MAX_LEN = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run_en,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [CHIP_W+REG_W-1:0]          req_addr,
  input  logic [$clog2(MAX_LEN+1)-1:0]     req_len,
  input  logic [MAX_LEN-1:0]               req_wdata,
  output logic                             busy,
  output logic                             done,
  output logic                             err,
  output logic [MAX_LEN-1:0]               rd_data,
  output logic                             ser_clk,
  output logic                             ser_dout,
  output logic                             ser_load,
  input  logic [NCHIP-1:0]                 ser_din
);
  localparam int ADDR_W = CHIP_W + REG_W;
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int CNT_W  = $clog2(DIV);
  localparam int HALF   = DIV / 2;
  localparam int SH_W   = ADDR_W + MAX_LEN;
  localparam int POS_W  = $clog2(SH_W + 1);

  logic              busy_q, done_q, err_q, wr_q;
  logic [CNT_W-1:0]  cnt;
  logic [POS_W-1:0]  pos, pos_last;
  logic [SH_W-1:0]   sh;
  logic [MAX_LEN-1:0] rd_q;
  logic [CHIP_W-1:0] chip_q;

  logic [CHIP_W-1:0]  req_chip;
  logic [MAX_LEN-1:0] data_al;
  logic bad_req, data_phase, bit_end, samp;

  assign req_chip   = req_addr[ADDR_W-1 -: CHIP_W];
  assign bad_req    = run_en || (req_len == '0) || (req_len > LEN_W'(MAX_LEN)) ||
                      (!req_write && (&req_chip));
  assign data_al    = req_write ? (req_wdata << (LEN_W'(MAX_LEN) - req_len)) : '0;
  assign data_phase = pos >= POS_W'(ADDR_W);
  assign bit_end    = cnt == CNT_W'(DIV - 1);
  assign samp       = cnt == CNT_W'(HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      wr_q     <= 1'b0;
      cnt      <= '0;
      pos      <= '0;
      pos_last <= '0;
      sh       <= '0;
      rd_q     <= '0;
      chip_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        if (run_en) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else begin
          if (samp && data_phase && !wr_q)
            rd_q <= {rd_q[MAX_LEN-2:0], ser_din[chip_q]};
          if (bit_end) begin
            cnt <= '0;
            if (pos == pos_last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              pos <= pos + 1'b1;
              sh  <= sh << 1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (req_valid) begin
        if (bad_req) begin
          err_q <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          cnt      <= '0;
          pos      <= '0;
          pos_last <= POS_W'(ADDR_W) + POS_W'(req_len) - 1'b1;
          sh       <= {req_addr, data_al};
          wr_q     <= req_write;
          chip_q   <= req_chip;
          if (!req_write) rd_q <= '0;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_data  = rd_q;
  assign ser_clk  = busy_q && (cnt >= CNT_W'(HALF));
  assign ser_dout = busy_q && sh[SH_W-1];
  assign ser_load = busy_q && data_phase;

  p_lockout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> !busy);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_dout && !ser_load));
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> ($stable(ser_dout) && $stable(ser_load)));
  p_load_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load) |-> !ser_clk);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(busy) && !ser_clk));
endmodule

// File: tb/tb_fe_cfg_master.sv
`timescale 1ns/1ps
module tb_fe_cfg_master;
  logic clk = 0, rst_n = 0, run_en = 0, req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [5:0]  req_len = 0;
  logic [31:0] req_wdata = 0;
  logic busy, done, err, ser_clk, ser_dout, ser_load;
  logic [31:0] rd_data;
  logic [15:0] ser_din = 0;

  int checks = 0, failures = 0, cyc = 0;
  bit din_const = 0, seen_done = 0, seen_err = 0, seen_bus = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  fe_cfg_master dut (.*);

  // reference model
  logic [1:0] q[$];
  bit m_busy = 0, m_done = 0, m_err = 0, m_wr = 0;
  int m_cnt = 0, m_chip = 0;
  logic [31:0] m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_rd = 0; q.delete();
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        if (run_en) begin m_busy = 0; m_err = 1; q.delete(); end
        else begin
          if (m_cnt == 3 && q[0][1] && !m_wr) m_rd = {m_rd[30:0], ser_din[m_chip]};
          if (m_cnt == 7) begin
            void'(q.pop_front()); m_cnt = 0;
            if (q.size() == 0) begin m_busy = 0; m_done = 1; end
          end else m_cnt++;
        end
      end else if (req_valid) begin
        if (run_en || req_len == 0 || req_len > 32 || (!req_write && req_addr[7:4] == 4'hF))
          m_err = 1;
        else begin
          for (int i = 7; i >= 0; i--) q.push_back({1'b0, req_addr[i]});
          for (int i = int'(req_len) - 1; i >= 0; i--)
            q.push_back({1'b1, req_write ? req_wdata[i] : 1'b0});
          m_busy = 1; m_cnt = 0; m_wr = req_write; m_chip = req_addr[7:4];
          if (!req_write) m_rd = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  logic prev_clk = 0, prev_dout = 0, prev_load = 0;
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_din = din_const ? 16'hFFFF : lfsr;
    if (rst_n) begin
      chk("R2 ser_clk", ser_clk, m_busy && m_cnt >= 4);
      chk("R3/R4 ser_dout", ser_dout, m_busy ? q[0][0] : 1'b0);
      chk("R3 ser_load", ser_load, m_busy ? q[0][1] : 1'b0);
      chk("R12 busy", busy, m_busy);
      chk("R7 done", done, m_done);
      chk("R8 err", err, m_err);
      chk("R6 rd_data", rd_data, m_rd);
      if (ser_clk && prev_clk) begin
        chk("R5 dout hold", ser_dout, prev_dout);
        chk("R5 load hold", ser_load, prev_load);
      end
      if (done) seen_done = 1;
      if (err) seen_err = 1;
      if (busy || ser_clk || ser_load || ser_dout) seen_bus = 1;
    end
    prev_clk = ser_clk; prev_dout = ser_dout; prev_load = ser_load;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(bit w, logic [7:0] a, logic [5:0] l, logic [31:0] d);
    seen_done = 0; seen_err = 0; seen_bus = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {ser_clk, ser_dout, ser_load, busy, done, err}, 0);
    chk("R1 reset rd_data", rd_data, 0);
    rst_n = 1;

    issue(1, 8'h35, 8, 32'hA5);           wait_idle(); chk("R7 write done", seen_done, 1);
    issue(1, 8'h1C, 32, 32'hDEADBEEF);    wait_idle(); chk("R4 len32 done", seen_done, 1);
    issue(1, 8'h02, 1, 32'h1);            wait_idle(); chk("R4 len1 done", seen_done, 1);
    issue(1, 8'hF7, 12, 32'h5A3);         wait_idle(); chk("R9 broadcast write ok", seen_done, 1);
    issue(0, 8'h24, 16, 0);               wait_idle(); chk("R6 read done", seen_done, 1);
    din_const = 1;
    issue(0, 8'h91, 5, 0);                wait_idle(); chk("R6 const read", rd_data, 32'h1F);
    din_const = 0;
    issue(0, 8'h7E, 32, 0);               wait_idle(); chk("R6 read32 done", seen_done, 1);

    issue(0, 8'hF3, 8, 0);                wait_idle();
    chk("R9 broadcast read err", seen_err, 1); chk("R9 no bus", seen_bus, 0);
    issue(1, 8'h11, 0, 1);                wait_idle();
    chk("R10 len0 err", seen_err, 1); chk("R10 len0 no bus", seen_bus, 0);
    issue(1, 8'h11, 33, 1);               wait_idle();
    chk("R10 len33 err", seen_err, 1); chk("R10 len33 no bus", seen_bus, 0);
    run_en = 1;
    issue(1, 8'h44, 4, 4'hF);             wait_idle();
    chk("R8 run err", seen_err, 1); chk("R8 no bus", seen_bus, 0);
    run_en = 0;

    issue(1, 8'h56, 20, 32'hABCDE);
    repeat (60) @(negedge clk);
    run_en = 1; @(negedge clk); run_en = 0;
    chk("R11 abort busy", busy, 0);
    wait_idle();
    chk("R11 abort err", seen_err, 1); chk("R11 no done", seen_done, 0);

    issue(0, 8'h63, 10, 0);
    repeat (30) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'hAA; req_len = 3; req_wdata = 7;
    @(negedge clk); req_valid = 0;
    wait_idle();
    chk("R12 ignored req", seen_err, 0); chk("R12 done", seen_done, 1);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule